// File: doc/BRIEF.md
# Serial DAC Write Sequencer

This block sits on the host side of a four-channel, 12-bit serial-input DAC. It takes one request at a time over a valid/ready handshake. A write request carries a channel, a code and two flags. One flag latches the shifted word into the channel's input register. The other updates all four outputs together. A clear request instead drives the DAC's asynchronous reset, with a chosen level on the line that selects the reset code.

For a write, the sequencer builds a 16-bit frame and shifts it out MSB first on a serial clock that it generates itself. It then issues the staging strobe and the commit strobe, each only if the request asked for it. Every setup, hold and pulse-width minimum is a nanosecond parameter. Each one is rounded up to whole system clock cycles using a clock-period parameter. When idle, all strobes, the chip select, the serial clock and the clear line rest high. A single-cycle `done_o` pulse marks the end of every sequence.

Top module: `dac_seq`

## Requirements
- R1: A write produces exactly 16 rising serial-clock edges while select is low. The frame is the 2-bit channel in bits 15:14, zeros in bits 13:12, and the code in bits 11:0, sent bit 15 first.
- R2: Serial data is stable at least ceil(25 ns / period) cycles before each rising serial-clock edge, and at least ceil(20 ns / period) cycles after it.
- R3: While select is low, every serial-clock high phase lasts at least ceil(30 ns / period) cycles and every low phase lasts at least ceil(50 ns / period) cycles.
- R4: Select falls at least ceil(55 ns / period) cycles before the first rising edge. It rises at least ceil(15 ns / period) cycles after the last rising edge, and only while the serial clock is high.
- R5: The staging strobe is high throughout shifting, and high at least ceil(40 ns / period) cycles before any rising edge. It falls no sooner than ceil(15 ns / period) cycles after the last rising edge. It is low for at least ceil(45 ns / period) cycles. It pulses once only when requested, copying the frame's code into the addressed channel's input register.
- R6: The commit strobe pulses low for at least ceil(45 ns / period) cycles, only when requested, after any staging pulse has ended. All four input registers then move to the outputs.
- R7: A clear request sets the code-select line, waits at least ceil(25 ns / period) cycles, then holds the clear line low for at least ceil(70 ns / period) cycles. Code-select high gives 0x800 and low gives 0x000 in every register. Code-select does not change while clear is low.
- R8: Ready is high only when idle. It falls the cycle after acceptance and stays low until the final strobe of the sequence has ended.
- R9: When idle, serial clock, select, staging strobe, commit strobe and clear line are all high.
- R10: `done_o` is high for exactly one cycle at the end of each write or clear sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_clear_i | input | 1 | 1: clear sequence, 0: write sequence |
| req_mid_i | input | 1 | Clear code select (1: mid-scale, 0: zero) |
| req_chan_i | input | 2 | Target channel |
| req_code_i | input | 12 | DAC code |
| req_stage_i | input | 1 | Pulse the staging strobe after the frame |
| req_commit_i | input | 1 | Pulse the commit strobe at the end |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| dac_sclk_o | output | 1 | Serial clock to DAC |
| dac_sel_no | output | 1 | Active-low chip select |
| dac_sdata_o | output | 1 | Serial data |
| dac_stage_no | output | 1 | Active-low input-register staging strobe |
| dac_commit_no | output | 1 | Active-low all-output update strobe |
| dac_clr_no | output | 1 | Active-low asynchronous clear |
| dac_clrmid_o | output | 1 | Clear code select level |

## Verification
The hardest case to reach is a fault that leaves every pin within its timing rules but still corrupts the DAC. Two examples: select rising while the serial clock is low, which gives the DAC's OR-gated shift clock one extra edge, or a strobe that updates the wrong register. The bench therefore drives a behavioural pin model of the DAC, with OR-gated clocking and transparent latches. It sweeps every channel, every flag combination and edge-case codes through this model, and compares all eight model registers with arithmetically predicted contents after each sequence. Commit-without-stage requests then expose any stale or misrouted input register.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_LOW, S_HIGH, S_STAGE, S_COMMIT, S_CLRSU, S_CLRLO
  } seq_state_e;

  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dac_seq_timer.sv
module dac_seq_timer #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dac_seq_shift.sv
module dac_seq_shift #(
  parameter int unsigned FRAME_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               shift_i,
  output logic               bit_o,
  output logic               last_o
);
  localparam int unsigned LEFT_W = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sr_q;
  logic [LEFT_W-1:0]  left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      left_q <= '0;
    end else if (load_i) begin
      sr_q   <= frame_i;
      left_q <= LEFT_W'(FRAME_W);
    end else if (shift_i) begin
      sr_q   <= {sr_q[FRAME_W-2:0], 1'b0};
      left_q <= left_q - 1'b1;
    end
  end

  assign bit_o  = sr_q[FRAME_W-1];
  assign last_o = (left_q == LEFT_W'(1));
endmodule

// File: rtl/dac_seq.sv
module dac_seq
  import dac_seq_pkg::*;
#(
  parameter int unsigned CODE_W        = 12,
  parameter int unsigned CH_W          = 2,
  parameter int unsigned PAD_W         = 2,
  parameter int unsigned CLK_PERIOD_NS = 5,
  parameter int unsigned T_DS_NS       = 25,
  parameter int unsigned T_DH_NS       = 20,
  parameter int unsigned T_CH_NS       = 30,
  parameter int unsigned T_CL_NS       = 50,
  parameter int unsigned T_CSS_NS      = 55,
  parameter int unsigned T_CSH_NS      = 15,
  parameter int unsigned T_LD1_NS      = 40,
  parameter int unsigned T_LD2_NS      = 15,
  parameter int unsigned T_LDRW_NS     = 45,
  parameter int unsigned T_LDDW_NS     = 45,
  parameter int unsigned T_RSSH_NS     = 25,
  parameter int unsigned T_RSTW_NS     = 70
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_clear_i,
  input  logic              req_mid_i,
  input  logic [CH_W-1:0]   req_chan_i,
  input  logic [CODE_W-1:0] req_code_i,
  input  logic              req_stage_i,
  input  logic              req_commit_i,
  output logic              done_o,
  output logic              dac_sclk_o,
  output logic              dac_sel_no,
  output logic              dac_sdata_o,
  output logic              dac_stage_no,
  output logic              dac_commit_no,
  output logic              dac_clr_no,
  output logic              dac_clrmid_o
);
  localparam int unsigned FRAME_W = CH_W + PAD_W + CODE_W;
  localparam int unsigned P       = CLK_PERIOD_NS;

  // phase lengths in cycles, each covering every rule that bounds it
  localparam int unsigned N_LOW   = max2(ns_to_cyc(T_CL_NS, P), ns_to_cyc(T_DS_NS, P));
  localparam int unsigned N_LOW0  = max2(N_LOW, max2(ns_to_cyc(T_CSS_NS, P), ns_to_cyc(T_LD1_NS, P)));
  localparam int unsigned N_HIGH  = max2(ns_to_cyc(T_CH_NS, P), ns_to_cyc(T_DH_NS, P));
  localparam int unsigned N_HIGHL = max2(N_HIGH, max2(ns_to_cyc(T_CSH_NS, P), ns_to_cyc(T_LD2_NS, P)));
  localparam int unsigned N_STAGE = ns_to_cyc(T_LDRW_NS, P);
  localparam int unsigned N_COMM  = ns_to_cyc(T_LDDW_NS, P);
  localparam int unsigned N_CLRSU = ns_to_cyc(T_RSSH_NS, P);
  localparam int unsigned N_CLRLO = ns_to_cyc(T_RSTW_NS, P);
  localparam int unsigned N_MAX   = max2(max2(max2(N_LOW0, N_HIGHL), max2(N_STAGE, N_COMM)),
                                         max2(N_CLRSU, N_CLRLO));
  localparam int unsigned CNT_W   = $clog2(N_MAX) + 1;

  localparam logic [CNT_W-1:0] L_LOW   = CNT_W'(N_LOW - 1);
  localparam logic [CNT_W-1:0] L_LOW0  = CNT_W'(N_LOW0 - 1);
  localparam logic [CNT_W-1:0] L_HIGH  = CNT_W'(N_HIGH - 1);
  localparam logic [CNT_W-1:0] L_HIGHL = CNT_W'(N_HIGHL - 1);
  localparam logic [CNT_W-1:0] L_STAGE = CNT_W'(N_STAGE - 1);
  localparam logic [CNT_W-1:0] L_COMM  = CNT_W'(N_COMM - 1);
  localparam logic [CNT_W-1:0] L_CLRSU = CNT_W'(N_CLRSU - 1);
  localparam logic [CNT_W-1:0] L_CLRLO = CNT_W'(N_CLRLO - 1);

  seq_state_e       state_q;
  logic             want_stage_q, want_commit_q;
  logic             tload, tzero, last_bit;
  logic [CNT_W-1:0] tval;
  logic             sh_load, sh_shift;

  assign req_ready_o = (state_q == S_IDLE);
  assign sh_load     = req_ready_o && req_valid_i && !req_clear_i;
  assign sh_shift    = (state_q == S_HIGH) && tzero && !last_bit;

  dac_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tload),
    .val_i  (tval),
    .zero_o (tzero)
  );

  dac_seq_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (sh_load),
    .frame_i ({req_chan_i, {PAD_W{1'b0}}, req_code_i}),
    .shift_i (sh_shift),
    .bit_o   (dac_sdata_o),
    .last_o  (last_bit)
  );

  always_comb begin
    tload = 1'b0;
    tval  = '0;
    unique case (state_q)
      S_IDLE:  if (req_valid_i) begin
                 tload = 1'b1;
                 tval  = req_clear_i ? L_CLRSU : L_LOW0;
               end
      S_LOW:   if (tzero) begin
                 tload = 1'b1;
                 tval  = last_bit ? L_HIGHL : L_HIGH;
               end
      S_HIGH:  if (tzero) begin
                 tload = 1'b1;
                 tval  = !last_bit   ? L_LOW   :
                         want_stage_q ? L_STAGE : L_COMM;
               end
      S_STAGE: if (tzero) begin
                 tload = 1'b1;
                 tval  = L_COMM;
               end
      S_CLRSU: if (tzero) begin
                 tload = 1'b1;
                 tval  = L_CLRLO;
               end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= S_IDLE;
      want_stage_q  <= 1'b0;
      want_commit_q <= 1'b0;
      done_o        <= 1'b0;
      dac_sclk_o    <= 1'b1;
      dac_sel_no    <= 1'b1;
      dac_stage_no  <= 1'b1;
      dac_commit_no <= 1'b1;
      dac_clr_no    <= 1'b1;
      dac_clrmid_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        S_IDLE: if (req_valid_i) begin
          if (req_clear_i) begin
            dac_clrmid_o <= req_mid_i;
            state_q      <= S_CLRSU;
          end else begin
            want_stage_q  <= req_stage_i;
            want_commit_q <= req_commit_i;
            dac_sel_no    <= 1'b0;
            dac_sclk_o    <= 1'b0;
            state_q       <= S_LOW;
          end
        end
        S_LOW: if (tzero) begin
          dac_sclk_o <= 1'b1;
          state_q    <= S_HIGH;
        end
        S_HIGH: if (tzero) begin
          if (!last_bit) begin
            dac_sclk_o <= 1'b0;
            state_q    <= S_LOW;
          end else begin
            // select rises with the clock still high: no extra shift edge
            dac_sel_no <= 1'b1;
            if (want_stage_q) begin
              dac_stage_no <= 1'b0;
              state_q      <= S_STAGE;
            end else if (want_commit_q) begin
              dac_commit_no <= 1'b0;
              state_q       <= S_COMMIT;
            end else begin
              done_o  <= 1'b1;
              state_q <= S_IDLE;
            end
          end
        end
        S_STAGE: if (tzero) begin
          dac_stage_no <= 1'b1;
          if (want_commit_q) begin
            dac_commit_no <= 1'b0;
            state_q       <= S_COMMIT;
          end else begin
            done_o  <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        S_COMMIT: if (tzero) begin
          dac_commit_no <= 1'b1;
          done_o        <= 1'b1;
          state_q       <= S_IDLE;
        end
        S_CLRSU: if (tzero) begin
          dac_clr_no <= 1'b0;
          state_q    <= S_CLRLO;
        end
        S_CLRLO: if (tzero) begin
          dac_clr_no <= 1'b1;
          done_o     <= 1'b1;
          state_q    <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dac_seq_chk.sv
module dac_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_i,
  input logic req_ready_o,
  input logic done_o,
  input logic dac_sclk_o,
  input logic dac_sel_no,
  input logic dac_stage_no,
  input logic dac_commit_no,
  input logic dac_clr_no,
  input logic dac_clrmid_o
);
  AST_SEL_RISE_CLK_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dac_sel_no) |-> dac_sclk_o); // R4
  AST_STAGE_HIGH_WHILE_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dac_sel_no |-> dac_stage_no); // R5
  AST_COMMIT_AFTER_STAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dac_commit_no |-> (dac_stage_no && dac_sel_no)); // R6
  AST_CLR_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dac_clr_no |-> (dac_sel_no && dac_stage_no && dac_commit_no)); // R7
  AST_CLRMID_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dac_clr_no && !$past(dac_clr_no)) |-> $stable(dac_clrmid_o)); // R7
  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o); // R8
  AST_IDLE_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (dac_sclk_o && dac_sel_no && dac_stage_no && dac_commit_no && dac_clr_no)); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
endmodule

bind dac_seq dac_seq_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_ready_o   (req_ready_o),
  .done_o        (done_o),
  .dac_sclk_o    (dac_sclk_o),
  .dac_sel_no    (dac_sel_no),
  .dac_stage_no  (dac_stage_no),
  .dac_commit_no (dac_commit_no),
  .dac_clr_no    (dac_clr_no),
  .dac_clrmid_o  (dac_clrmid_o)
);

// File: tb/tb_dac_seq.sv
`timescale 1ns/1ps
module tb_dac_seq;
  localparam int PER = 5;
  function automatic int cyc(int ns);
    int c;
    c = (ns + PER - 1) / PER;
    return (c < 1) ? 1 : c;
  endfunction
  localparam int E_DS = cyc(25), E_DH = cyc(20), E_CH = cyc(30), E_CL = cyc(50);
  localparam int E_CSS = cyc(55), E_CSH = cyc(15), E_LD1 = cyc(40), E_LD2 = cyc(15);
  localparam int E_LDRW = cyc(45), E_LDDW = cyc(45), E_RSSH = cyc(25), E_RSTW = cyc(70);

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic valid = 0, clear = 0, mid = 0, stage = 0, commit = 0;
  logic [1:0] chan = 0;
  logic [11:0] code = 0;
  logic ready, done, sclk, sel_n, sdata, stage_n, commit_n, clr_n, clrmid;

  dac_seq #(.CLK_PERIOD_NS(PER)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(ready),
    .req_clear_i(clear), .req_mid_i(mid), .req_chan_i(chan), .req_code_i(code),
    .req_stage_i(stage), .req_commit_i(commit), .done_o(done),
    .dac_sclk_o(sclk), .dac_sel_no(sel_n), .dac_sdata_o(sdata),
    .dac_stage_no(stage_n), .dac_commit_no(commit_n), .dac_clr_no(clr_n),
    .dac_clrmid_o(clrmid)
  );

  int checks = 0, fails = 0;
  function automatic void chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endfunction

  // behavioural DAC pin model and timing monitor
  logic [15:0] m_sr = 0;
  logic [11:0] m_in [4];
  logic [11:0] m_out[4];
  logic [11:0] e_in [4];
  logic [11:0] e_out[4];
  bit mon_on = 0;
  logic p_clk = 1, p_sel = 1, p_sdi = 0, p_stage = 1, p_commit = 1, p_clr = 1, p_or = 1, p_mid = 0;
  int run_clk = 0, run_sdi = 0, run_stage = 0, run_commit = 0, run_clr = 0;
  int since_rise = 1000, since_sel = 1000, since_stage = 1000, since_mid = 1000;
  int nrise = 0, nstage = 0, ncommit = 0;

  always @(negedge clk) if (mon_on) begin
    logic orn;
    orn = sel_n | sclk;
    since_rise++; since_sel++; since_stage++; since_mid++;
    if (sclk && !p_clk && !sel_n) begin
      chk(run_sdi >= E_DS, "R2 setup", run_sdi, E_DS);
      chk(run_clk >= E_CL, "R3 low phase", run_clk, E_CL);
      if (nrise == 0) chk(since_sel >= E_CSS, "R4 select lead", since_sel, E_CSS);
      chk(stage_n && since_stage >= E_LD1, "R5 stage high before rise", since_stage, E_LD1);
      nrise++;
      since_rise = 0;
    end
    if (!sclk && p_clk && !sel_n) chk(run_clk >= E_CH, "R3 high phase", run_clk, E_CH);
    if (sdata != p_sdi && !p_sel && !sel_n && nrise > 0)
      chk(since_rise >= E_DH, "R2 hold", since_rise, E_DH);
    if (sel_n && !p_sel) begin
      chk(sclk == 1'b1, "R4 select rises with clock high", sclk, 1);
      chk(since_rise >= E_CSH, "R4 select lag", since_rise, E_CSH);
    end
    if (!sel_n && p_sel) begin since_sel = 0; nrise = 0; end
    if (!stage_n && p_stage) begin
      chk(since_rise >= E_LD2 && sel_n, "R5 stage fall after last rise", since_rise, E_LD2);
      nstage++;
    end
    if (stage_n && !p_stage) begin
      chk(run_stage >= E_LDRW, "R5 stage width", run_stage, E_LDRW);
      since_stage = 0;
    end
    if (!commit_n && p_commit) begin
      chk(stage_n, "R6 commit after stage", stage_n, 1);
      ncommit++;
    end
    if (commit_n && !p_commit) chk(run_commit >= E_LDDW, "R6 commit width", run_commit, E_LDDW);
    if (!clr_n && p_clr) chk(since_mid >= E_RSSH, "R7 code select lead", since_mid, E_RSSH);
    if (clr_n && !p_clr) chk(run_clr >= E_RSTW, "R7 clear width", run_clr, E_RSTW);
    if (clrmid != p_mid) since_mid = 0;
    // model: OR-gated shift clock, transparent latches, asynchronous clear
    if (orn && !p_or) m_sr = {m_sr[14:0], sdata};
    if (!stage_n) m_in[m_sr[15:14]] = m_sr[11:0];
    if (!commit_n) for (int i = 0; i < 4; i++) m_out[i] = m_in[i];
    if (!clr_n) for (int i = 0; i < 4; i++) begin
      m_in[i]  = clrmid ? 12'h800 : 12'h000;
      m_out[i] = clrmid ? 12'h800 : 12'h000;
    end
    run_clk    = (sclk == p_clk) ? run_clk + 1 : 1;
    run_sdi    = (sdata == p_sdi) ? run_sdi + 1 : 1;
    run_stage  = (stage_n == p_stage) ? run_stage + 1 : 1;
    run_commit = (commit_n == p_commit) ? run_commit + 1 : 1;
    run_clr    = (clr_n == p_clr) ? run_clr + 1 : 1;
    p_clk = sclk; p_sel = sel_n; p_sdi = sdata; p_stage = stage_n;
    p_commit = commit_n; p_clr = clr_n; p_or = orn; p_mid = clrmid;
  end

  task automatic run_req(bit c, bit m, int ch, int cd, bit ldr, bit ldd);
    int n, busy_bad;
    @(negedge clk);
    nstage = 0; ncommit = 0;
    clear = c; mid = m; chan = 2'(ch); code = 12'(cd); stage = ldr; commit = ldd; valid = 1;
    while (!ready) @(negedge clk);
    @(negedge clk);
    valid = 0;
    n = 0; busy_bad = 0;
    while (!done && n < 2000) begin
      if (ready) busy_bad++;
      n++;
      @(negedge clk);
    end
    chk(busy_bad == 0, "R8 ready low while busy", busy_bad, 0);
    chk(done == 1'b1, "R10 done at end", done, 1);
    #1;
    if (c) begin
      for (int i = 0; i < 4; i++) begin
        e_in[i]  = m ? 12'h800 : 12'h000;
        e_out[i] = e_in[i];
      end
    end else begin
      chk(nrise == 16, "R1 rising edge count", nrise, 16);
      chk(m_sr == {2'(ch), 2'b00, 12'(cd)}, "R1 frame", m_sr, {2'(ch), 2'b00, 12'(cd)});
      chk(nstage == int'(ldr), "R5 stage only on request", nstage, ldr);
      chk(ncommit == int'(ldd), "R6 commit only on request", ncommit, ldd);
      if (ldr) e_in[ch] = 12'(cd);
      if (ldd) for (int i = 0; i < 4; i++) e_out[i] = e_in[i];
    end
    for (int i = 0; i < 4; i++) begin
      chk(m_in[i] == e_in[i], c ? "R7 input reg" : "R5 input reg", m_in[i], e_in[i]);
      chk(m_out[i] == e_out[i], c ? "R7 output reg" : "R6 output reg", m_out[i], e_out[i]);
    end
    @(negedge clk);
    chk(done == 1'b0, "R10 done single cycle", done, 0);
    chk({sclk, sel_n, stage_n, commit_n, clr_n, ready} == 6'h3f, "R9 idle pins",
        {sclk, sel_n, stage_n, commit_n, clr_n, ready}, 6'h3f);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int codes[6];
    codes = '{12'h000, 12'hfff, 12'h800, 12'h7ff, 12'ha5a, 12'h5a5};
    for (int i = 0; i < 4; i++) begin
      m_in[i] = 0; m_out[i] = 0; e_in[i] = 0; e_out[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({sclk, sel_n, stage_n, commit_n, clr_n} == 5'h1f, "R9 reset pins",
        {sclk, sel_n, stage_n, commit_n, clr_n}, 5'h1f);
    chk(ready == 1'b1 && done == 1'b0, "R8 reset handshake", {ready, done}, 2'b10);
    mon_on = 1;
    run_req(1, 1, 0, 0, 0, 0);   // R7 mid-scale clear
    run_req(1, 0, 0, 0, 0, 0);   // R7 zero clear
    for (int k = 0; k < 6; k++)
      for (int f = 0; f < 4; f++)
        for (int ch = 0; ch < 4; ch++)
          run_req(0, 0, ch, codes[k] ^ (ch * 12'h111), f[0], f[1]);
    run_req(1, 1, 0, 0, 0, 0);
    run_req(0, 0, 2, 12'h3c3, 0, 1); // R6 commit without stage: outputs keep cleared input regs
    run_req(0, 0, 2, 12'h3c3, 1, 0);
    run_req(0, 0, 1, 12'h0f0, 1, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule